// File: doc/BRIEF.md
# Level Interrupt Aggregator with Routed Parent Outputs

This block gathers a bank of level-sensitive interrupt sources and reports them on several first-level parent interrupt lines. The sources are grouped into 32-bit words, with one to four words. All parent lines share a single set of enable registers. Each parent line also has a fixed routing mask per word, so it reports only its own subset of the pending sources. A source that no parent's mask covers counts as unused. Its enable and wake-enable bits read as zero, and it can never raise an output.

Software uses a plain register bus. Each word has three registers: an enable register, a read-only status register that shows the live source levels, and a wake-enable register. Sources are levels, so status needs no acknowledge. To mask or unmask one source, software reads the enable register, changes the bit and writes the value back. A separate wake output reports any source armed for wakeup. A low-power input gates the parent lines off but leaves the wake output running.

Top module: `lvl_irq_agg`

## Requirements
- R1: Reading the status register of word w (byte address 0x10*w + 0x4) returns the current levels of sources 32*w to 32*w+31, with source 32*w in bit 0. Writes to a status register change no register.
- R2: Each word w has its enable register at 0x10*w + 0x0 and its wake-enable register at 0x10*w + 0x8. Address bits 1:0 are ignored. Any other address, including words at or beyond NUM_WORDS, reads as zero and ignores writes. A read returns the value written last, restricted to the used bits.
- R3: Parent line p is registered. At each clock edge it takes the OR, over all words w, of (status AND enable AND route[p][w]). It changes at the first edge after a source changes. After an enable write it changes at the edge that follows the edge that stores the write.
- R4: The routing parameter is packed parent-major, then by word. The mask route[p][w] occupies bits 32*(p*NUM_WORDS+w) and up.
- R5: When routing is disabled by parameter, every parent line covers all 32 bits of every word.
- R6: A source bit that no parent's route mask covers is unused. Its enable and wake-enable bits always read 0, and it never raises a parent line or the wake line.
- R7: The wake output is registered. At each edge it takes the OR of (status AND wake-enable) over all words. It is not affected by low power. Wake-enable registers reset to 0.
- R8: While low_power is high at an edge, every parent line is low after that edge.
- R9: Reset leaves each enable register at the parameter FWD_INIT restricted to the used bits, and leaves all parent lines and the wake line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_WORDS*32 | Level interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| low_power | input | 1 | Gates all parent lines low |
| parent_irq | output | NUM_PARENTS | Parent interrupt lines |
| wake_irq | output | 1 | Wakeup request |

## Verification
The bench sets every single source bit in turn, under a routing map with overlapping, disjoint and empty regions. A design that sliced the routing vector word-major would light the wrong parent. A design that left uncovered bits writable would show them in readback. The bench also samples each line one edge before and one edge after a change. This catches an output that is combinational or one stage too late. Status writes, out-of-range words and low power with wake armed are checked at the ports. A second instance with routing disabled shows that every bit of every word reaches every parent.

// File: rtl/lvl_irq_agg_pkg.sv
package lvl_irq_agg_pkg;
   localparam int WORD_BITS = 32;
   localparam int MAX_WORDS = 4;
   localparam int WIDX_LSB  = 4;
   localparam int RSEL_LSB  = 2;
   localparam int MAP_BITS  = 6;

   typedef enum logic [1:0] {
      RSEL_ENABLE = 2'd0,
      RSEL_STATUS = 2'd1,
      RSEL_WAKE   = 2'd2,
      RSEL_NONE   = 2'd3
   } rsel_e;
endpackage

// File: rtl/lvl_irq_agg_regs.sv
module lvl_irq_agg_regs
   import lvl_irq_agg_pkg::*;
#(
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 8,
   parameter logic [NUM_WORDS*WORD_BITS-1:0] FWD_INIT = '0,
   parameter logic [NUM_WORDS*WORD_BITS-1:0] USED     = '1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_WORDS*WORD_BITS-1:0]    src_in,
   input  logic                              bus_sel,
   input  logic                              bus_wr,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [WORD_BITS-1:0]              bus_wdata,
   output logic [WORD_BITS-1:0]              bus_rdata,
   output logic [NUM_WORDS*WORD_BITS-1:0]    en_o,
   output logic [NUM_WORDS*WORD_BITS-1:0]    wake_en_o
);
   localparam logic [NUM_WORDS*WORD_BITS-1:0] EN_RST = FWD_INIT & USED;

   logic       in_map;
   logic [1:0] widx;
   rsel_e      rsel;

   assign in_map = (bus_addr >> MAP_BITS) == '0;
   assign widx   = bus_addr[WIDX_LSB +: 2];
   assign rsel   = rsel_e'(bus_addr[RSEL_LSB +: 2]);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      assign hit = bus_sel && bus_wr && in_map && (widx == 2'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[w*WORD_BITS +: WORD_BITS]      <= EN_RST[w*WORD_BITS +: WORD_BITS];
            wake_en_o[w*WORD_BITS +: WORD_BITS] <= '0;
         end else if (hit) begin
            if (rsel == RSEL_ENABLE)
               en_o[w*WORD_BITS +: WORD_BITS] <= bus_wdata & USED[w*WORD_BITS +: WORD_BITS];
            if (rsel == RSEL_WAKE)
               wake_en_o[w*WORD_BITS +: WORD_BITS] <= bus_wdata & USED[w*WORD_BITS +: WORD_BITS];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (in_map && (widx == 2'(w))) begin
            case (rsel)
               RSEL_ENABLE: bus_rdata = en_o[w*WORD_BITS +: WORD_BITS];
               RSEL_STATUS: bus_rdata = src_in[w*WORD_BITS +: WORD_BITS];
               RSEL_WAKE:   bus_rdata = wake_en_o[w*WORD_BITS +: WORD_BITS];
               default:     bus_rdata = '0;
            endcase
         end
      end
   end

   // R1
   stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && rsel == RSEL_STATUS) |=> ($stable(en_o) && $stable(wake_en_o)));
endmodule

// File: rtl/lvl_irq_agg_fan.sv
module lvl_irq_agg_fan
   import lvl_irq_agg_pkg::*;
#(
   parameter int NUM_WORDS   = 4,
   parameter int NUM_PARENTS = 2,
   parameter logic [NUM_PARENTS*NUM_WORDS*WORD_BITS-1:0] ROUTE = '1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_WORDS*WORD_BITS-1:0]    src_in,
   input  logic [NUM_WORDS*WORD_BITS-1:0]    en_i,
   input  logic                              low_power,
   output logic [NUM_PARENTS-1:0]            parent_irq
);
   localparam int SPAN = NUM_WORDS * WORD_BITS;

   logic [SPAN-1:0] live;
   assign live = src_in & en_i;

   for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_parent
      logic hit;
      assign hit = |(live & ROUTE[p*SPAN +: SPAN]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) parent_irq[p] <= 1'b0;
         else        parent_irq[p] <= hit && !low_power;
      end
   end

   // R8
   lp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |=> (parent_irq == '0));
endmodule

// File: rtl/lvl_irq_agg_wake.sv
module lvl_irq_agg_wake
   import lvl_irq_agg_pkg::*;
#(
   parameter int NUM_WORDS = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_WORDS*WORD_BITS-1:0] src_in,
   input  logic [NUM_WORDS*WORD_BITS-1:0] wake_en_i,
   output logic                           wake_irq
);
   logic [NUM_WORDS-1:0] word_hit;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_hit[w] = |(src_in[w*WORD_BITS +: WORD_BITS] & wake_en_i[w*WORD_BITS +: WORD_BITS]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_irq <= 1'b0;
      else        wake_irq <= |word_hit;
   end

   // R7
   wake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_in & wake_en_i)) |=> wake_irq);
   // R7
   wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src_in & wake_en_i)) |=> !wake_irq);
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
   import lvl_irq_agg_pkg::*;
#(
   parameter int NUM_WORDS   = 4,
   parameter int NUM_PARENTS = 2,
   parameter int ADDR_W      = 8,
   parameter bit ROUTE_EN    = 1'b0,
   parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0] ROUTE_MASK = '1,
   parameter logic [NUM_WORDS*32-1:0]             FWD_INIT   = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_WORDS*32-1:0] src_in,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic                    low_power,
   output logic [NUM_PARENTS-1:0]  parent_irq,
   output logic                    wake_irq
);
   localparam int SPAN = NUM_WORDS * WORD_BITS;
   localparam logic [NUM_PARENTS*SPAN-1:0] ROUTE_EFF = ROUTE_EN ? ROUTE_MASK : '1;

   function automatic logic [SPAN-1:0] calc_used();
      logic [SPAN-1:0] acc = '0;
      for (int p = 0; p < NUM_PARENTS; p++) acc |= ROUTE_EFF[p*SPAN +: SPAN];
      return acc;
   endfunction

   localparam logic [SPAN-1:0] USED = calc_used();

   if (NUM_WORDS < 1 || NUM_WORDS > MAX_WORDS) begin : g_bad_words
      $error("lvl_irq_agg: NUM_WORDS must lie in 1..4");
   end
   if (NUM_PARENTS < 1) begin : g_bad_parents
      $error("lvl_irq_agg: NUM_PARENTS must be at least 1");
   end
   if (ADDR_W < MAP_BITS) begin : g_bad_addr
      $error("lvl_irq_agg: ADDR_W too narrow for the register map");
   end

   logic [SPAN-1:0] en_w;
   logic [SPAN-1:0] wake_en_w;

   lvl_irq_agg_regs #(
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W),
      .FWD_INIT  (FWD_INIT),
      .USED      (USED)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .en_o      (en_w),
      .wake_en_o (wake_en_w)
   );

   lvl_irq_agg_fan #(
      .NUM_WORDS   (NUM_WORDS),
      .NUM_PARENTS (NUM_PARENTS),
      .ROUTE       (ROUTE_EFF)
   ) u_fan (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in),
      .en_i       (en_w),
      .low_power  (low_power),
      .parent_irq (parent_irq)
   );

   lvl_irq_agg_wake #(
      .NUM_WORDS (NUM_WORDS)
   ) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .wake_en_i (wake_en_w),
      .wake_irq  (wake_irq)
   );

   for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_chk
      // R3
      par_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!low_power && |(src_in & en_w & ROUTE_EFF[p*SPAN +: SPAN])) |=> parent_irq[p]);
      // R3
      par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(src_in & en_w & ROUTE_EFF[p*SPAN +: SPAN])) |=> !parent_irq[p]);
   end

   // R6
   unused_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_w | wake_en_w) & ~USED) == '0);
endmodule

// File: tb/lvl_irq_agg_bench.sv
module lvl_irq_agg_bench;
   localparam int NW = 2;
   localparam int NP = 3;
   localparam logic [NP*NW*32-1:0] ROUTE =
      {32'hF000_0000, 32'h0000_0000,   // p2 w1, p2 w0
       32'h0000_00FF, 32'hFF00_0000,   // p1 w1, p1 w0
       32'h0000_0000, 32'h0000_FFFF};  // p0 w1, p0 w0
   localparam logic [NW*32-1:0] FWD  = {32'h1000_0001, 32'h0000_00F0};
   localparam logic [NW*32-1:0] USED = {32'hF000_00FF, 32'hFF00_FFFF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NW*32-1:0] src = '0;
   logic bus_sel = 1'b0, bus_wr = 1'b0, lp = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata2;
   logic [NP-1:0] par;
   logic [1:0] par2;
   logic wake, wake2;

   int n_chk = 0, n_fail = 0;
   logic [NW*32-1:0] en_m, wk_m, en2_m, wk2_m;

   always #5 clk = ~clk;

   lvl_irq_agg #(.NUM_WORDS(NW), .NUM_PARENTS(NP), .ADDR_W(8), .ROUTE_EN(1'b1),
                 .ROUTE_MASK(ROUTE), .FWD_INIT(FWD)) u_lvl_irq_agg (
      .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
      .low_power(lp), .parent_irq(par), .wake_irq(wake));

   lvl_irq_agg #(.NUM_WORDS(NW), .NUM_PARENTS(2), .ADDR_W(8), .ROUTE_EN(1'b0),
                 .FWD_INIT(FWD)) u_lvl_irq_agg_open (
      .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
      .low_power(lp), .parent_irq(par2), .wake_irq(wake2));

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] exp_par(logic [NW*32-1:0] s, logic [NW*32-1:0] e, logic l);
      logic [NP-1:0] r;
      for (int p = 0; p < NP; p++) r[p] = |(s & e & ROUTE[p*NW*32 +: NW*32]) && !l;
      return r;
   endfunction

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (a[7:6] == 2'b00 && a[5:4] < 2'(NW)) begin
         if (a[3:2] == 2'd0) begin
            en_m[a[4]*32 +: 32]  = d & USED[a[4]*32 +: 32];
            en2_m[a[4]*32 +: 32] = d;
         end
         if (a[3:2] == 2'd2) begin
            wk_m[a[4]*32 +: 32]  = d & USED[a[4]*32 +: 32];
            wk2_m[a[4]*32 +: 32] = d;
         end
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] d2);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = rdata; d2 = rdata2;
      bus_sel = 1'b0;
   endtask

   task automatic check_outs(string req);
      check(req, 64'(par), 64'(exp_par(src, en_m, lp)));
      check(req, 64'(wake), 64'(|(src & wk_m)));
      check(req, 64'(par2), 64'({2{(|(src & en2_m)) && !lp}}));
      check(req, 64'(wake2), 64'(|(src & wk2_m)));
   endtask

   logic done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, d2;
      logic [31:0] lfsr;
      logic [NP-1:0] prev;
      en_m = FWD & USED; en2_m = FWD; wk_m = '0; wk2_m = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", 64'({par, wake, par2, wake2}), 64'h0);
      rst_n = 1'b1;
      rd(8'h00, d, d2); check("R9", 64'(d), 64'h0000_00F0); check("R9", 64'(d2), 64'h0000_00F0);
      rd(8'h10, d, d2); check("R9", 64'(d), 64'h1000_0001); check("R9", 64'(d2), 64'h1000_0001);
      rd(8'h08, d, d2); check("R7", 64'(d), 64'h0);

      // R6 unused bits read zero; R2 readback
      wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h08, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h00, d, d2); check("R6", 64'(d), 64'hFF00_FFFF); check("R2", 64'(d2), 64'hFFFF_FFFF);
      rd(8'h1B, d, d2); check("R6", 64'(d), 64'hF000_00FF);
      rd(8'h0C, d, d2); check("R2 unmapped", 64'(d), 64'h0);
      rd(8'h20, d, d2); check("R2 out of range", 64'(d), 64'h0);
      rd(8'h40, d, d2); check("R2 high addr", 64'(d), 64'h0);
      wr(8'h20, 32'h0); wr(8'h40, 32'h0);
      rd(8'h00, d, d2); check("R2 stray write", 64'(d), 64'hFF00_FFFF);

      // R3 R4 R5 R6 R7 single-bit sweep with latency checks
      for (int b = 0; b < NW*32; b++) begin
         @(negedge clk);
         prev = par;
         src = '0; src[b] = 1'b1;
         #1 check("R3 latency", 64'(par), 64'(prev));
         @(negedge clk);
         check_outs($sformatf("R4 R5 R6 bit %0d", b));
      end

      // R1 status read, status write ignored
      src = {32'hA5A5_0F0F, 32'h1234_5678};
      rd(8'h04, d, d2); check("R1", 64'(d), 64'h1234_5678);
      rd(8'h14, d, d2); check("R1", 64'(d), 64'hA5A5_0F0F);
      wr(8'h04, 32'h0); wr(8'h14, 32'h0);
      rd(8'h10, d, d2); check("R1 status write", 64'(d), 64'hF000_00FF);
      rd(8'h18, d, d2); check("R1 status write", 64'(d), 64'hF000_00FF);

      // R3 enable write latency: read-modify-write clears one bit
      src = '0; src[3] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R3 pre", 64'(par[0]), 64'h1);
      rd(8'h00, d, d2);
      wr(8'h00, d & ~32'h8);
      check("R3 enable edge", 64'(par[0]), 64'h1);
      @(negedge clk);
      check("R3 enable+1", 64'(par[0]), 64'h0);
      wr(8'h00, d);
      @(negedge clk);
      check("R3 unmask", 64'(par[0]), 64'h1);

      // R8 low power gates parents, wake stays
      lp = 1'b1;
      @(negedge clk);
      check("R8", 64'({par, par2}), 64'h0);
      check("R8 wake", 64'({wake, wake2}), 64'h3);
      lp = 1'b0;
      @(negedge clk);
      check_outs("R8 release");

      // R3 R7 pseudo-random patterns
      lfsr = 32'hACE1_1234;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (i % 25 == 0) wr({3'b000, lfsr[3], 2'b00, lfsr[4], 1'b0}, lfsr ^ 32'h5A5A_C3C3);
         @(negedge clk);
         src = {lfsr & {lfsr[15:0], lfsr[31:16]}, lfsr & ~{lfsr[7:0], lfsr[31:8]}};
         lp = (i % 37 == 5);
         @(negedge clk);
         check_outs("R3 R7 R8 pattern");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule